// File: doc/BRIEF.md
# Omega Multistage Switch Network

This block is a blocking multistage interconnect that connects `NUM_PORTS` sources to `NUM_PORTS` sinks through `log2(NUM_PORTS)` switching stages. Each stage first rewires its lanes with a perfect shuffle, then passes them through a column of 2x2 switches. Each switch chooses between pass-through and crossover on its own. A register closes each stage, so a new group of packets, called a wave, can enter on every clock cycle.

Each input lane carries three things: a valid flag, a destination index and a payload. The block does not look up routes in a table. Each switch works out its setting from one bit of the packet's source index and the same bit of its destination index. The network is blocking, so two packets can ask for the same internal link. When that happens, one packet goes on and the other is dropped. The block reports, per source lane, whether that source's packet was delivered or blocked. It does not retry or hold a dropped packet; the surrounding logic decides what to do with it.

Top module: `omega_net`

## Requirements
- R1: While `rst_ni` is low, `out_valid_o`, `delivered_o` and `blocked_o` are all zero.
- R2: A wave on the inputs ahead of a rising edge shows up on the outputs after exactly log2(NUM_PORTS) rising edges (3 for 8 ports), and not before.
- R3: Lane i is wired into the next column at the position whose index is i rotated left by one bit. At stage k (k=0 first), a switch compares source bit log2(NUM_PORTS)-1-k with the same destination bit: equal bits give pass-through, unequal bits give crossover. As a result, a packet that is not blocked leaves on output index equal to its destination. It carries its payload unchanged, and `out_src_o` for that output holds its input index.
- R4: The identity pattern and every cyclic shift (destination = source + c mod NUM_PORTS) deliver all NUM_PORTS packets with nothing blocked.
- R5: Two valid packets may reach one switch and need the same switch output. The packet on the upper input (the even lane) goes on. The packet on the lower input is dropped, and bit `blocked_o[src]` is set for its source. With 8 ports, packets 2→7 and 6→4 collide: source 2 is delivered and source 6 is blocked.
- R6: An input whose valid bit is low has no effect. Its destination and payload reach no output. It blocks no other packet, and it sets neither its delivered bit nor its blocked bit.
- R7: For every wave, `delivered_o` and `blocked_o` never share a set bit, and their OR equals the set of valid inputs of that wave. The number of set bits in `out_valid_o` equals the number of set bits in `delivered_o`.
- R8: Waves entered on consecutive cycles move through the stages independently. A packet dropped in one wave frees its link for the other packets of that wave.
- R9: Conflicts are also found at stages after the first. With 8 ports, packets 0→0 and 2→1 pass the first stage and collide at the second: source 0 is delivered and source 2 is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | NUM_PORTS | Per-lane packet valid |
| in_dest_i | input | NUM_PORTS x ADDR_W | Per-lane destination index |
| in_data_i | input | NUM_PORTS x DATA_W | Per-lane payload |
| out_valid_o | output | NUM_PORTS | Output lane holds a delivered packet |
| out_src_o | output | NUM_PORTS x ADDR_W | Source index of the packet on each output lane |
| out_data_o | output | NUM_PORTS x DATA_W | Payload on each output lane |
| delivered_o | output | NUM_PORTS | Per-source flag: packet of that source reached its output |
| blocked_o | output | NUM_PORTS | Per-source flag: packet of that source was dropped on a conflict |

## Verification
The bench builds the block with 8 ports and an 8-bit payload. That gives three stages, which is enough to place a collision at the first stage and a separate collision at the middle stage, each with a known winner. The bench covers the identity pattern and all seven cyclic shifts, run back to back. A pseudo-random stream of waves exercises cases where a packet dropped early frees a link that a later stage would otherwise contend for. The bench predicts every wave with its own path model, which tracks which link each packet occupies after each stage. This model is separate from the switch logic in the design.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // destination lane of perfect-shuffle wiring: rotate lane index left by one
  function automatic int shuffle_lane(input int idx, input int lg);
    int mask;
    mask = (1 << lg) - 1;
    return ((idx << 1) | (idx >> (lg - 1))) & mask;
  endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int BIT    = 2
) (
  input  logic [1:0]             vld_i,
  input  logic [1:0][ADDR_W-1:0] src_i,
  input  logic [1:0][ADDR_W-1:0] dst_i,
  input  logic [1:0][DATA_W-1:0] dat_i,
  output logic [1:0]             vld_o,
  output logic [1:0][ADDR_W-1:0] src_o,
  output logic [1:0][ADDR_W-1:0] dst_o,
  output logic [1:0][DATA_W-1:0] dat_o,
  output logic [1:0]             drop_o
);

  logic [1:0] want;   // requested output port per input
  logic       clash;
  logic [1:0] keep;
  logic [1:0] up_hit;
  logic [1:0] lo_hit;

  // equal src/dst bit -> pass (port stays), else cross (port flips)
  assign want[0] = src_i[0][BIT] ^ dst_i[0][BIT];
  assign want[1] = ~(src_i[1][BIT] ^ dst_i[1][BIT]);

  assign clash  = vld_i[0] & vld_i[1] & (want[0] == want[1]);
  assign keep   = {vld_i[1] & ~clash, vld_i[0]};
  assign drop_o = {clash, 1'b0};

  assign up_hit = {keep[0] & want[0], keep[0] & ~want[0]};
  assign lo_hit = {keep[1] & want[1], keep[1] & ~want[1]};

  for (genvar o = 0; o < 2; o++) begin : g_out
    always_comb begin
      vld_o[o] = up_hit[o] | lo_hit[o];
      src_o[o] = '0;
      dst_o[o] = '0;
      dat_o[o] = '0;
      if (up_hit[o]) begin
        src_o[o] = src_i[0];
        dst_o[o] = dst_i[0];
        dat_o[o] = dat_i[0];
      end else if (lo_hit[o]) begin
        src_o[o] = src_i[1];
        dst_o[o] = dst_i[1];
        dat_o[o] = dat_i[1];
      end
    end
  end

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int NUM_PORTS = 8,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int STAGE     = 0
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_PORTS-1:0]                vld_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    src_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    dst_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]    dat_i,
  input  logic [NUM_PORTS-1:0]                blk_i,
  output logic [NUM_PORTS-1:0]                vld_o,
  output logic [NUM_PORTS-1:0][ADDR_W-1:0]    src_o,
  output logic [NUM_PORTS-1:0][ADDR_W-1:0]    dst_o,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]    dat_o,
  output logic [NUM_PORTS-1:0]                blk_o
);

  localparam int BIT  = ADDR_W - 1 - STAGE;
  localparam int HALF = NUM_PORTS / 2;

  logic [NUM_PORTS-1:0]             sh_vld;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] sh_src;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] sh_dst;
  logic [NUM_PORTS-1:0][DATA_W-1:0] sh_dat;

  logic [NUM_PORTS-1:0]             sw_vld;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] sw_src;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] sw_dst;
  logic [NUM_PORTS-1:0][DATA_W-1:0] sw_dat;
  logic [NUM_PORTS-1:0]             drop_pos;
  logic [NUM_PORTS-1:0]             blk_nxt;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_shuffle
    localparam int TO = omega_pkg::shuffle_lane(i, ADDR_W);
    assign sh_vld[TO] = vld_i[i];
    assign sh_src[TO] = src_i[i];
    assign sh_dst[TO] = dst_i[i];
    assign sh_dat[TO] = dat_i[i];
  end

  for (genvar s = 0; s < HALF; s++) begin : g_sw
    omega_switch #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BIT    (BIT)
    ) u_sw (
      .vld_i  (sh_vld[2*s+1:2*s]),
      .src_i  (sh_src[2*s+1:2*s]),
      .dst_i  (sh_dst[2*s+1:2*s]),
      .dat_i  (sh_dat[2*s+1:2*s]),
      .vld_o  (sw_vld[2*s+1:2*s]),
      .src_o  (sw_src[2*s+1:2*s]),
      .dst_o  (sw_dst[2*s+1:2*s]),
      .dat_o  (sw_dat[2*s+1:2*s]),
      .drop_o (drop_pos[2*s+1:2*s])
    );
  end

  // drops are reported by source lane, merged with earlier stages
  always_comb begin
    blk_nxt = blk_i;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (drop_pos[i]) blk_nxt[sh_src[i]] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= '0;
      src_o <= '0;
      dst_o <= '0;
      dat_o <= '0;
      blk_o <= '0;
    end else begin
      vld_o <= sw_vld;
      src_o <= sw_src;
      dst_o <= sw_dst;
      dat_o <= sw_dat;
      blk_o <= blk_nxt;
    end
  end

endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int NUM_PORTS = 8,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = $clog2(NUM_PORTS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_PORTS-1:0]             in_valid_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] in_dest_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] in_data_i,
  output logic [NUM_PORTS-1:0]             out_valid_o,
  output logic [NUM_PORTS-1:0][ADDR_W-1:0] out_src_o,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] out_data_o,
  output logic [NUM_PORTS-1:0]             delivered_o,
  output logic [NUM_PORTS-1:0]             blocked_o
);

  localparam int NSTG = ADDR_W;

  logic [NSTG:0][NUM_PORTS-1:0]             vld_q;
  logic [NSTG:0][NUM_PORTS-1:0][ADDR_W-1:0] src_q;
  logic [NSTG:0][NUM_PORTS-1:0][ADDR_W-1:0] dst_q;
  logic [NSTG:0][NUM_PORTS-1:0][DATA_W-1:0] dat_q;
  logic [NSTG:0][NUM_PORTS-1:0]             blk_q;

  assign vld_q[0] = in_valid_i;
  assign dst_q[0] = in_dest_i;
  assign dat_q[0] = in_data_i;
  assign blk_q[0] = '0;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_src
    assign src_q[0][i] = ADDR_W'(i);
  end

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    omega_stage #(
      .NUM_PORTS (NUM_PORTS),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .STAGE     (k)
    ) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (vld_q[k]),
      .src_i  (src_q[k]),
      .dst_i  (dst_q[k]),
      .dat_i  (dat_q[k]),
      .blk_i  (blk_q[k]),
      .vld_o  (vld_q[k+1]),
      .src_o  (src_q[k+1]),
      .dst_o  (dst_q[k+1]),
      .dat_o  (dat_q[k+1]),
      .blk_o  (blk_q[k+1])
    );
  end

  assign out_valid_o = vld_q[NSTG];
  assign out_src_o   = src_q[NSTG];
  assign out_data_o  = dat_q[NSTG];
  assign blocked_o   = blk_q[NSTG];

  always_comb begin
    delivered_o = '0;
    for (int j = 0; j < NUM_PORTS; j++) begin
      if (vld_q[NSTG][j]) delivered_o[src_q[NSTG][j]] = 1'b1;
    end
  end

endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
  parameter int NUM_PORTS = 8,
  localparam int ADDR_W   = $clog2(NUM_PORTS)
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [NUM_PORTS-1:0]             in_valid_i,
  input logic [NUM_PORTS-1:0]             out_valid_o,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0] out_src_o,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0] fin_dst_i,
  input logic [NUM_PORTS-1:0]             delivered_o,
  input logic [NUM_PORTS-1:0]             blocked_o
);

  // valid set of each wave, delayed to line up with the outputs
  logic [ADDR_W-1:0][NUM_PORTS-1:0] vpipe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpipe <= '0;
    end else begin
      for (int k = ADDR_W - 1; k > 0; k--) vpipe[k] <= vpipe[k-1];
      vpipe[0] <= in_valid_i;
    end
  end

  a_r7_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (delivered_o & blocked_o) == '0);

  a_r7_accounted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (delivered_o | blocked_o) == vpipe[ADDR_W-1]);

  a_r7_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(out_valid_o) == $countones(delivered_o));

  a_r2_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vpipe[ADDR_W-1] == '0) |-> (out_valid_o == '0 && blocked_o == '0));

  for (genvar j = 0; j < NUM_PORTS; j++) begin : g_lane
    a_r3_lands_on_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[j] |-> (fin_dst_i[j] == ADDR_W'(j)));

    a_r6_src_was_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[j] |-> vpipe[ADDR_W-1][out_src_o[j]]);
  end

endmodule

bind omega_net omega_net_chk #(
  .NUM_PORTS (NUM_PORTS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .out_src_o   (out_src_o),
  .fin_dst_i   (dst_q[NSTG]),
  .delivered_o (delivered_o),
  .blocked_o   (blocked_o)
);

// File: tb/omega_net_bench.sv
`timescale 1ns/1ps
module omega_net_bench;

  localparam int P  = 8;
  localparam int LG = 3;
  localparam int W  = 8;
  localparam int MAXW = 16;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic [P-1:0]             in_valid = '0;
  logic [P-1:0][LG-1:0]     in_dest = '0;
  logic [P-1:0][W-1:0]      in_data = '0;
  logic [P-1:0]             out_valid;
  logic [P-1:0][LG-1:0]     out_src;
  logic [P-1:0][W-1:0]      out_data;
  logic [P-1:0]             delivered;
  logic [P-1:0]             blocked;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [P-1:0]         w_vld [MAXW];
  logic [P-1:0][LG-1:0] w_dst [MAXW];
  logic [P-1:0][W-1:0]  w_dat [MAXW];
  logic [15:0]          lfsr = 16'hACE1;

  always #5 clk = ~clk;

  omega_net #(.NUM_PORTS(P), .DATA_W(W)) u_omega_net (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_dest_i   (in_dest),
    .in_data_i   (in_data),
    .out_valid_o (out_valid),
    .out_src_o   (out_src),
    .out_data_o  (out_data),
    .delivered_o (delivered),
    .blocked_o   (blocked)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // path model: link held by each packet after each stage
  task automatic model(input logic [P-1:0] v, input logic [P-1:0][LG-1:0] d,
                       output logic [P-1:0] ev, output logic [P-1:0][LG-1:0] esrc,
                       output logic [P-1:0] eblk, output logic [P-1:0] edel);
    int link [P];
    int prev [P];
    bit alive [P];
    ev = '0; esrc = '0; eblk = '0; edel = '0;
    for (int i = 0; i < P; i++) begin
      alive[i] = v[i];
      prev[i]  = i;
    end
    for (int k = 0; k < LG; k++) begin
      for (int i = 0; i < P; i++)
        link[i] = ((i << (k + 1)) | (int'(d[i]) >> (LG - 1 - k))) & (P - 1);
      for (int i = 0; i < P; i++) begin
        for (int j = i + 1; j < P; j++) begin
          if (alive[i] && alive[j] && link[i] == link[j]) begin
            if (((prev[i] >> (LG - 1)) & 1) == 0) begin
              alive[j] = 1'b0; eblk[j] = 1'b1;
            end else begin
              alive[i] = 1'b0; eblk[i] = 1'b1;
            end
          end
        end
      end
      for (int i = 0; i < P; i++) prev[i] = link[i];
    end
    for (int i = 0; i < P; i++) begin
      if (alive[i]) begin
        ev[d[i]]   = 1'b1;
        esrc[d[i]] = LG'(i);
        edel[i]    = 1'b1;
      end
    end
  endtask

  task automatic compare_wave(input int w, input string req);
    logic [P-1:0]         ev;
    logic [P-1:0][LG-1:0] esrc;
    logic [P-1:0]         eblk;
    logic [P-1:0]         edel;
    model(w_vld[w], w_dst[w], ev, esrc, eblk, edel);
    check(out_valid == ev, req, "out_valid", 64'(out_valid), 64'(ev));
    check(blocked == eblk, req, "blocked", 64'(blocked), 64'(eblk));
    check(delivered == edel, req, "delivered", 64'(delivered), 64'(edel));
    for (int j = 0; j < P; j++) begin
      if (ev[j]) begin
        check(out_src[j] == esrc[j], req, "out_src", 64'(out_src[j]), 64'(esrc[j]));
        check(out_data[j] == w_dat[w][esrc[j]], req, "out_data",
              64'(out_data[j]), 64'(w_dat[w][esrc[j]]));
      end
    end
  endtask

  // waves 0..n-1 enter back to back; each is checked LG edges after entry
  task automatic run_waves(input int n, input string req);
    for (int t = 0; t < n + LG - 1; t++) begin
      @(negedge clk);
      if (t < n) begin
        in_valid = w_vld[t];
        in_dest  = w_dst[t];
        in_data  = w_dat[t];
      end else begin
        in_valid = '0;
        in_dest  = '0;
        in_data  = '0;
      end
      @(posedge clk);
      #1;
      if (t >= LG - 1) compare_wave(t - LG + 1, req);
    end
  endtask

  task automatic clear_wave(input int w);
    w_vld[w] = '0;
    w_dst[w] = '0;
    for (int i = 0; i < P; i++) w_dat[w][i] = W'(w * 16 + i + 5);
  endtask

  task automatic t_reset;
    #1;
    check(out_valid == '0, "R1", "out_valid in reset", 64'(out_valid), 0);
    check(delivered == '0, "R1", "delivered in reset", 64'(delivered), 0);
    check(blocked == '0, "R1", "blocked in reset", 64'(blocked), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_latency;
    @(negedge clk);
    in_valid = '1;
    for (int i = 0; i < P; i++) begin
      in_dest[i] = LG'(i);
      in_data[i] = W'(8'h30 + i);
    end
    repeat (LG - 1) @(posedge clk);
    #1;
    check(out_valid == '0, "R2", "early out_valid", 64'(out_valid), 0);
    @(negedge clk);
    in_valid = '0;
    @(posedge clk);
    #1;
    check(out_valid == '1, "R2", "out_valid at latency", 64'(out_valid), 64'hFF);
  endtask

  task automatic t_identity;
    clear_wave(0);
    w_vld[0] = '1;
    for (int i = 0; i < P; i++) w_dst[0][i] = LG'(i);
    run_waves(1, "R3");
  endtask

  task automatic t_shifts;
    for (int c = 1; c < P; c++) begin
      clear_wave(c - 1);
      w_vld[c-1] = '1;
      for (int i = 0; i < P; i++) w_dst[c-1][i] = LG'((i + c) % P);
    end
    run_waves(P - 1, "R4");
    check(out_valid == '1, "R4", "last shift all delivered", 64'(out_valid), 64'hFF);
  endtask

  task automatic t_first_stage_conflict;
    clear_wave(0);
    w_vld[0][2] = 1'b1; w_dst[0][2] = 3'd7;
    w_vld[0][6] = 1'b1; w_dst[0][6] = 3'd4;
    run_waves(1, "R5");
    check(blocked == 8'h40, "R5", "blocked src 6", 64'(blocked), 64'h40);
    check(delivered == 8'h04, "R5", "delivered src 2", 64'(delivered), 64'h04);
    check(out_valid == 8'h80, "R5", "winner on out 7", 64'(out_valid), 64'h80);
  endtask

  task automatic t_mid_stage_conflict;
    clear_wave(0);
    w_vld[0][0] = 1'b1; w_dst[0][0] = 3'd0;
    w_vld[0][2] = 1'b1; w_dst[0][2] = 3'd1;
    run_waves(1, "R9");
    check(blocked == 8'h04, "R9", "blocked src 2", 64'(blocked), 64'h04);
    check(delivered == 8'h01, "R9", "delivered src 0", 64'(delivered), 64'h01);
  endtask

  task automatic t_invalid_ignored;
    clear_wave(0);
    for (int i = 0; i < P; i++) begin
      w_vld[0][i] = (i < P / 2);
      w_dst[0][i] = LG'(i % (P / 2));
    end
    run_waves(1, "R6");
    check(blocked == '0, "R6", "no block from idle lanes", 64'(blocked), 0);
    check(out_valid == 8'h0F, "R6", "only valid lanes out", 64'(out_valid), 64'h0F);
    check(delivered == 8'h0F, "R6", "idle lanes not delivered", 64'(delivered), 64'h0F);
  endtask

  task automatic t_stream;
    for (int w = 0; w < 12; w++) begin
      clear_wave(w);
      for (int i = 0; i < P; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        w_vld[w][i] = lfsr[0] | lfsr[5];
        w_dst[w][i] = lfsr[9:7];
      end
    end
    run_waves(12, "R8");
  endtask

  initial begin
    t_reset();
    t_latency();
    t_identity();
    t_shifts();
    t_first_stage_conflict();
    t_mid_stage_conflict();
    t_invalid_ignored();
    t_stream();
    check((delivered & blocked) == '0, "R7", "disjoint flags", 64'(delivered & blocked), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule